// File: doc/BRIEF.md
# Multicycle Register-Transfer Datapath

This block is the datapath half of a 32-bit multicycle load/store processor with no controller inside it. It holds the program counter, the instruction register, a memory data latch, a 32-entry register file, the two operand latches, the ALU and its result latch, and the multiplexers that feed the ALU, the register file write port, the memory address and the next program counter. Every select, write enable and the 4-bit ALU function code are primary inputs. An external sequencer, or a testbench, walks an instruction through fetch, decode, execute, memory and write-back by driving those inputs one clock at a time.

Memory is outside the block. Each word read from memory, whether an instruction or a load value, arrives on `mem_rdata`. The address is driven on `mem_addr`. The program counter and the two operand latches appear as outputs. A decode step therefore doubles as a register read-back: the registers named by the two source fields appear on `a_q` and `b_q` one clock later.

Top module: `mcdp_datapath`

## Requirements
- R1: A synchronous active-high `rst` clears the program counter, every register of the file, the instruction register, the memory data latch, the ALU result latch, and both `a_q` and `b_q`.
- R2: With `addr_sel`=0, `mem_addr` equals `pc_q`. With `ir_we`=1, the instruction register loads `mem_rdata` at the edge. With `opa_sel`=0, `opb_sel`=01, `alu_ctl`=0010 (add), `npc_sel`=00 and `pc_we`=1, the PC advances by 4.
- R3: While `ir_we` is 0, the instruction register holds its value whatever `mem_rdata` carries.
- R4: At every edge, `a_q` and `b_q` capture the register file entries addressed by bits [25:21] and [20:16] of the instruction register.
- R5: `opb_sel`=10 feeds the ALU the sign-extended bits [15:0] of the instruction, and `opa_sel`=1 feeds it `a_q`. With `reg_we`=1, `wdst_sel`=0 selects bits [20:16] as the write address, and `wdata_sel`=0 writes the ALU result latch.
- R6: `opb_sel`=00 feeds `b_q` to the ALU. `alu_ctl` codes are 0000 AND, 0001 OR, 0010 add, 0011 XOR, 0110 subtract, 0111 signed set-less-than, 1100 NOR, and any other code gives zero. `wdst_sel`=1 selects bits [15:11] as the write address.
- R7: Register 0 always reads as zero, and writes to it are discarded.
- R8: `opb_sel`=11 feeds the ALU the sign-extended immediate shifted left by 2. With `pc_we_cond`=1 and `npc_sel`=01, the PC loads the ALU result latch when the ALU result is zero and holds otherwise. With both `pc_we` and `pc_we_cond` at 0, the PC holds.
- R9: With `npc_sel`=10 and `pc_we`=1, the PC loads the jump target, formed from PC[31:28], then instruction bits [25:0], then two zero bits.
- R10: With `addr_sel`=1, `mem_addr` equals the ALU result latch. The memory data latch captures `mem_rdata` at every edge, and `wdata_sel`=1 writes that latch into the register file.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pc_we | input | 1 | Unconditional PC write |
| pc_we_cond | input | 1 | PC write qualified by ALU zero |
| addr_sel | input | 1 | Address select: 0 PC, 1 ALU result latch |
| ir_we | input | 1 | Instruction register load |
| reg_we | input | 1 | Register file write |
| wdst_sel | input | 1 | Write address: 0 rt field, 1 rd field |
| wdata_sel | input | 1 | Write data: 0 ALU result latch, 1 memory data latch |
| opa_sel | input | 1 | First operand: 0 PC, 1 A latch |
| opb_sel | input | 2 | Second operand: 00 B, 01 four, 10 immediate, 11 immediate x4 |
| npc_sel | input | 2 | Next PC: 00 ALU, 01 ALU latch, 10 jump target |
| alu_ctl | input | 4 | ALU function code |
| mem_rdata | input | 32 | Word read from memory |
| mem_addr | output | 32 | Memory address |
| pc_q | output | 32 | Program counter |
| a_q | output | 32 | First operand latch |
| b_q | output | 32 | Second operand latch |

## Verification
The assertions assume that the controls form a sensible sequence. A fetch step always uses the add code with the constant-four operand. A jump is a plain PC write, not combined with a conditional write. Reset is held for at least one edge before any checked step. The bench drives every input on the falling edge through one task per pipeline step, clears all enables between steps, and applies only the code combinations listed in the requirements, so none of these assumptions is ever broken.

// File: rtl/mcdp_pkg.sv
`timescale 1ns/1ps
package mcdp_pkg;
  localparam int XLEN     = 32;
  localparam int RF_DEPTH = 32;
  localparam int RAW      = $clog2(RF_DEPTH);
  localparam int IMM_W    = 16;
  localparam int JT_W     = 26;
  localparam int RS_LSB   = 21;
  localparam int RT_LSB   = 16;
  localparam int RD_LSB   = 11;

  typedef enum logic [3:0] {
    ALU_AND = 4'b0000,
    ALU_OR  = 4'b0001,
    ALU_ADD = 4'b0010,
    ALU_XOR = 4'b0011,
    ALU_SUB = 4'b0110,
    ALU_SLT = 4'b0111,
    ALU_NOR = 4'b1100
  } alu_fn_e;

  localparam logic [1:0] OPB_B    = 2'b00;
  localparam logic [1:0] OPB_FOUR = 2'b01;
  localparam logic [1:0] OPB_IMM  = 2'b10;
  localparam logic [1:0] OPB_IMM4 = 2'b11;

  localparam logic [1:0] NPC_ALU  = 2'b00;
  localparam logic [1:0] NPC_LAT  = 2'b01;
  localparam logic [1:0] NPC_JMP  = 2'b10;
endpackage

// File: rtl/mcdp_regfile.sv
`timescale 1ns/1ps
module mcdp_regfile #(
  parameter int W     = 32,
  parameter int DEPTH = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr0,
  input  logic [AW-1:0] raddr1,
  output logic [W-1:0]  rdata0,
  output logic [W-1:0]  rdata1
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we && (waddr != '0)) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata0 = (raddr0 == '0) ? '0 : mem[raddr0];
  assign rdata1 = (raddr1 == '0) ? '0 : mem[raddr1];
endmodule

// File: rtl/mcdp_alu.sv
`timescale 1ns/1ps
module mcdp_alu
  import mcdp_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  input  logic [3:0]   fn,
  output logic [W-1:0] res,
  output logic         zero
);
  always_comb begin
    unique case (fn)
      ALU_AND: res = opa & opb;
      ALU_OR:  res = opa | opb;
      ALU_ADD: res = opa + opb;
      ALU_XOR: res = opa ^ opb;
      ALU_SUB: res = opa - opb;
      ALU_SLT: res = {{(W-1){1'b0}}, ($signed(opa) < $signed(opb))};
      ALU_NOR: res = ~(opa | opb);
      default: res = '0;
    endcase
  end

  assign zero = (res == '0);
endmodule

// File: rtl/mcdp_opsel.sv
`timescale 1ns/1ps
module mcdp_opsel
  import mcdp_pkg::*;
#(
  parameter int W     = 32,
  parameter int IMMW  = 16
) (
  input  logic            opa_sel,
  input  logic [1:0]      opb_sel,
  input  logic [W-1:0]    pc,
  input  logic [W-1:0]    a,
  input  logic [W-1:0]    b,
  input  logic [IMMW-1:0] imm,
  output logic [W-1:0]    opa,
  output logic [W-1:0]    opb
);
  logic [W-1:0] imm_sx;
  assign imm_sx = {{(W-IMMW){imm[IMMW-1]}}, imm};
  assign opa = opa_sel ? a : pc;

  always_comb begin
    unique case (opb_sel)
      OPB_B:    opb = b;
      OPB_FOUR: opb = W'(4);
      OPB_IMM:  opb = imm_sx;
      default:  opb = {imm_sx[W-3:0], 2'b00};
    endcase
  end
endmodule

// File: rtl/mcdp_datapath.sv
`timescale 1ns/1ps
module mcdp_datapath
  import mcdp_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             pc_we,
  input  logic             pc_we_cond,
  input  logic             addr_sel,
  input  logic             ir_we,
  input  logic             reg_we,
  input  logic             wdst_sel,
  input  logic             wdata_sel,
  input  logic             opa_sel,
  input  logic [1:0]       opb_sel,
  input  logic [1:0]       npc_sel,
  input  logic [3:0]       alu_ctl,
  input  logic [XLEN-1:0]  mem_rdata,
  output logic [XLEN-1:0]  mem_addr,
  output logic [XLEN-1:0]  pc_q,
  output logic [XLEN-1:0]  a_q,
  output logic [XLEN-1:0]  b_q
);
  logic [XLEN-1:0] ir_q, mdr_q, alu_q;
  logic [XLEN-1:0] rf_rd0, rf_rd1, opa, opb, alu_res, wdata, npc;
  logic [RAW-1:0]  rs_a, rt_a, rd_a, waddr;
  logic            alu_zero, pc_load;

  assign rs_a = ir_q[RS_LSB +: RAW];
  assign rt_a = ir_q[RT_LSB +: RAW];
  assign rd_a = ir_q[RD_LSB +: RAW];

  assign waddr = wdst_sel ? rd_a : rt_a;
  assign wdata = wdata_sel ? mdr_q : alu_q;

  mcdp_regfile #(.W(XLEN), .DEPTH(RF_DEPTH)) u_rf (
    .clk(clk), .rst(rst), .we(reg_we), .waddr(waddr), .wdata(wdata),
    .raddr0(rs_a), .raddr1(rt_a), .rdata0(rf_rd0), .rdata1(rf_rd1)
  );

  mcdp_opsel #(.W(XLEN), .IMMW(IMM_W)) u_opsel (
    .opa_sel(opa_sel), .opb_sel(opb_sel), .pc(pc_q), .a(a_q), .b(b_q),
    .imm(ir_q[IMM_W-1:0]), .opa(opa), .opb(opb)
  );

  mcdp_alu #(.W(XLEN)) u_alu (
    .opa(opa), .opb(opb), .fn(alu_ctl), .res(alu_res), .zero(alu_zero)
  );

  always_comb begin
    unique case (npc_sel)
      NPC_ALU: npc = alu_res;
      NPC_LAT: npc = alu_q;
      NPC_JMP: npc = {pc_q[XLEN-1 -: XLEN-JT_W-2], ir_q[JT_W-1:0], 2'b00};
      default: npc = alu_res;
    endcase
  end

  assign pc_load  = pc_we | (pc_we_cond & alu_zero);
  assign mem_addr = addr_sel ? alu_q : pc_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q  <= '0;
      ir_q  <= '0;
      mdr_q <= '0;
      a_q   <= '0;
      b_q   <= '0;
      alu_q <= '0;
    end else begin
      if (pc_load) pc_q <= npc;
      if (ir_we)   ir_q <= mem_rdata;
      mdr_q <= mem_rdata;
      a_q   <= rf_rd0;
      b_q   <= rf_rd1;
      alu_q <= alu_res;
    end
  end
endmodule

// File: rtl/mcdp_checker.sv
`timescale 1ns/1ps
module mcdp_checker (
  input logic        clk,
  input logic        rst,
  input logic        pc_we,
  input logic        pc_we_cond,
  input logic        opa_sel,
  input logic [1:0]  opb_sel,
  input logic [1:0]  npc_sel,
  input logic [3:0]  alu_ctl,
  input logic [4:0]  rs_f,
  input logic [31:0] pc_q,
  input logic [31:0] a_q,
  input logic [31:0] b_q
);
  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (pc_q == '0 && a_q == '0 && b_q == '0)); // R1

  AST_FETCH_STEP: assert property (@(posedge clk) disable iff (rst)
    (pc_we && !opa_sel && opb_sel == 2'b01 && alu_ctl == 4'b0010 && npc_sel == 2'b00)
    |=> pc_q == $past(pc_q) + 32'd4); // R2

  AST_R0_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rs_f == 5'd0) |=> a_q == '0); // R7

  AST_PC_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!pc_we && !pc_we_cond) |=> $stable(pc_q)); // R8

  AST_JUMP_REGION: assert property (@(posedge clk) disable iff (rst)
    (pc_we && npc_sel == 2'b10)
    |=> (pc_q[31:28] == $past(pc_q[31:28]) && pc_q[1:0] == 2'b00)); // R9
endmodule

bind mcdp_datapath mcdp_checker u_chk (
  .clk(clk), .rst(rst), .pc_we(pc_we), .pc_we_cond(pc_we_cond),
  .opa_sel(opa_sel), .opb_sel(opb_sel), .npc_sel(npc_sel), .alu_ctl(alu_ctl),
  .rs_f(ir_q[25:21]), .pc_q(pc_q), .a_q(a_q), .b_q(b_q)
);

// File: tb/mcdp_datapath_tb.sv
`timescale 1ns/1ps
module mcdp_datapath_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pc_we, pc_we_cond, addr_sel, ir_we, reg_we, wdst_sel, wdata_sel, opa_sel;
  logic [1:0]  opb_sel, npc_sel;
  logic [3:0]  alu_ctl;
  logic [31:0] mem_rdata, mem_addr, pc_q, a_q, b_q;
  logic [31:0] exp_pc;
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  mcdp_datapath u_dut (
    .clk(clk), .rst(rst), .pc_we(pc_we), .pc_we_cond(pc_we_cond),
    .addr_sel(addr_sel), .ir_we(ir_we), .reg_we(reg_we), .wdst_sel(wdst_sel),
    .wdata_sel(wdata_sel), .opa_sel(opa_sel), .opb_sel(opb_sel),
    .npc_sel(npc_sel), .alu_ctl(alu_ctl), .mem_rdata(mem_rdata),
    .mem_addr(mem_addr), .pc_q(pc_q), .a_q(a_q), .b_q(b_q)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    pc_we = 0; pc_we_cond = 0; addr_sel = 0; ir_we = 0; reg_we = 0;
    wdst_sel = 0; wdata_sel = 0; opa_sel = 0; opb_sel = 2'b00;
    npc_sel = 2'b00; alu_ctl = 4'b0010; mem_rdata = 32'h0BAD_0BAD;
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [31:0] mk_i(input logic [5:0] op, input int rs, input int rt, input logic [15:0] imm);
    return {op, 5'(rs), 5'(rt), imm};
  endfunction

  function automatic logic [31:0] mk_r(input int rs, input int rt, input int rd);
    return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'h00, 6'h20};
  endfunction

  // fetch step: R2
  task automatic ph_fetch(input logic [31:0] instr);
    idle();
    ir_we = 1; pc_we = 1; opb_sel = 2'b01; alu_ctl = 4'b0010; mem_rdata = instr;
    #1 chk("R2 fetch address is PC", mem_addr, exp_pc);
    tick();
    exp_pc = exp_pc + 32'd4;
    chk("R2 PC advances by 4", pc_q, exp_pc);
  endtask

  // decode step; memory bus carries junk to show the IR holds (R3)
  task automatic ph_decode();
    idle();
    opb_sel = 2'b11; alu_ctl = 4'b0010; mem_rdata = 32'hDEAD_BEEF;
    tick();
  endtask

  task automatic observe(input int rs, input int rt, input logic [31:0] ea, input logic [31:0] eb, input string tag);
    ph_fetch(mk_r(rs, rt, 0));
    ph_decode();
    chk({tag, " A latch"}, a_q, ea);
    chk({tag, " B latch"}, b_q, eb);
  endtask

  task automatic run_addi(input int rt, input int rs, input logic [15:0] imm);
    ph_fetch(mk_i(6'h08, rs, rt, imm));
    ph_decode();
    idle(); opa_sel = 1; opb_sel = 2'b10; alu_ctl = 4'b0010; tick();
    idle(); reg_we = 1; wdst_sel = 0; wdata_sel = 0; tick();
  endtask

  task automatic run_rop(input int rd, input int rs, input int rt, input logic [3:0] fn);
    ph_fetch(mk_r(rs, rt, rd));
    ph_decode();
    idle(); opa_sel = 1; opb_sel = 2'b00; alu_ctl = fn; tick();
    idle(); reg_we = 1; wdst_sel = 1; wdata_sel = 0; tick();
  endtask

  task automatic run_branch(input int rs, input int rt, input logic [15:0] off, input bit taken, input string tag);
    logic [31:0] base;
    ph_fetch(mk_i(6'h04, rs, rt, off));
    base = exp_pc;
    ph_decode();
    idle(); opa_sel = 1; opb_sel = 2'b00; alu_ctl = 4'b0110;
    pc_we_cond = 1; npc_sel = 2'b01; tick();
    if (taken) exp_pc = base + {{14{off[15]}}, off, 2'b00};
    chk(tag, pc_q, exp_pc);
  endtask

  task automatic test_reset();
    chk("R1 PC after reset", pc_q, 32'h0);
    chk("R1 A after reset", a_q, 32'h0);
    chk("R1 B after reset", b_q, 32'h0);
    chk("R2 address equals PC after reset", mem_addr, 32'h0);
  endtask

  task automatic test_immediates();
    run_addi(1, 0, 16'h00FF);
    run_addi(2, 0, 16'hFFFC);
    observe(1, 2, 32'h0000_00FF, 32'hFFFF_FFFC, "R5 R4 R3 immediate writes");
  endtask

  task automatic test_alu_ops();
    run_rop(3, 1, 2, 4'b0010);
    run_rop(4, 1, 2, 4'b0110);
    observe(3, 4, 32'h0000_00FB, 32'h0000_0103, "R6 add/sub");
    run_rop(5, 1, 2, 4'b0000);
    run_rop(6, 1, 2, 4'b0001);
    observe(5, 6, 32'h0000_00FC, 32'hFFFF_FFFF, "R6 and/or");
    run_rop(7, 2, 1, 4'b0111);
    run_rop(8, 1, 2, 4'b1100);
    observe(7, 8, 32'h0000_0001, 32'h0000_0000, "R6 slt/nor");
    run_rop(10, 1, 2, 4'b0011);
    run_rop(11, 1, 2, 4'b1111);
    observe(10, 11, 32'hFFFF_FF03, 32'h0000_0000, "R6 xor/unused code");
  endtask

  task automatic test_r0();
    run_addi(0, 1, 16'h0007);
    observe(0, 1, 32'h0, 32'h0000_00FF, "R7 register zero");
  endtask

  task automatic test_branches();
    run_branch(1, 1, 16'h0003, 1'b1, "R8 branch taken forward");
    run_branch(1, 2, 16'h0003, 1'b0, "R8 branch not taken");
    run_branch(3, 3, 16'hFFFE, 1'b1, "R8 branch taken backward");
    idle(); tick();
    chk("R8 PC holds with no write", pc_q, exp_pc);
  endtask

  task automatic test_jump();
    ph_fetch({6'h02, 26'h000_0040});
    ph_decode();
    idle(); pc_we = 1; npc_sel = 2'b10; tick();
    exp_pc = {exp_pc[31:28], 26'h000_0040, 2'b00};
    chk("R9 jump target", pc_q, exp_pc);
  endtask

  task automatic test_load();
    ph_fetch(mk_i(6'h23, 1, 9, 16'h0008));
    ph_decode();
    idle(); opa_sel = 1; opb_sel = 2'b10; alu_ctl = 4'b0010; tick();
    idle(); addr_sel = 1; mem_rdata = 32'hCAFE_F00D;
    #1 chk("R10 address from ALU latch", mem_addr, 32'h0000_0107);
    tick();
    idle(); reg_we = 1; wdst_sel = 0; wdata_sel = 1; tick();
    observe(9, 1, 32'hCAFE_F00D, 32'h0000_00FF, "R10 load write-back");
  endtask

  task automatic test_reset_mid();
    idle(); rst = 1; tick(); rst = 0;
    exp_pc = 32'h0;
    chk("R1 PC cleared mid-run", pc_q, 32'h0);
    observe(1, 9, 32'h0, 32'h0, "R1 registers cleared");
  endtask

  initial begin
    idle();
    exp_pc = 32'h0;
    rst = 1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 0;
    test_reset();
    test_immediates();
    test_alu_ops();
    test_r0();
    test_branches();
    test_jump();
    test_load();
    test_reset_mid();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule